// File: doc/BRIEF.md
# Health-Gated Random Word Controller

This block takes single raw bits from a physical noise source and turns them into 128-bit random words for a consumer. No word is released unless the source has been judged healthy. Two health checks watch the raw stream. One is a stuck-source detector that runs all the time. The other is a window test that counts ones. The window test runs once after reset, and again whenever software pulses a retest request.

Conditioning is a simple compression step. Each pair of raw bits is XORed into one output bit, so a word costs 256 raw samples. Finished words are offered on a valid/ready port. Once any health check fails, the block enters a failure state that only reset leaves. It drops the word it was building and any word it was offering, so nothing built from raw bits taken after the fault can reach the consumer.

Top module: `trng_gate_ctrl`

## Requirements
- R1: After reset, `status` is 0 (startup test), `rnd_valid` is low, and `fault` and `healthy` are low.
- R2: The startup window is the first 1024 raw samples. On the 1024th sample, if the window's count of ones lies in 462..562 inclusive, `status` becomes 1 (running) after that edge. Otherwise it becomes 3 (failed).
- R3: While `status` is not 1, `rnd_valid` stays low. In particular, no word is offered before the startup test passes.
- R4: If 64 consecutive raw samples have the same value, the block fails on the edge of the 64th sample, in the startup, running or retest state. A run of 63 equal samples followed by a change does not cause a failure.
- R5: Each word bit is the XOR of two consecutive raw samples taken while collecting. The first pair gives bit 127 and the last pair gives bit 0. A word becomes valid right after its 256th sample.
- R6: A valid word holds its value until `rnd_ready` is high at a clock edge. Raw samples that arrive while a word is held are not used in any word.
- R7: When a failure is detected, the held word and the partly built word are discarded. `rnd_valid` is low from that edge on, and no word is offered afterwards.
- R8: The failed state (`status` 3, `fault` high, `healthy` low) persists until reset. A retest request in that state has no effect.
- R9: A retest pulse in the running state with no word held moves `status` to 2 after that edge, with `rnd_valid` low. The next 1024 samples are judged with the R2 limits: a pass returns to 1 and a fail goes to 3.
- R10: A retest request that arrives while a word is held is remembered. `status` stays 1 until the word is taken, and becomes 2 on the second edge counting from the edge that takes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_bit | input | 1 | Raw noise sample |
| ent_vld | input | 1 | Sample strobe for `ent_bit` |
| retest_req | input | 1 | Software request to rerun the window test |
| rnd_word | output | 128 | Random word offered to the consumer |
| rnd_valid | output | 1 | `rnd_word` is available |
| rnd_ready | input | 1 | Consumer takes the word |
| fault | output | 1 | Sticky failure indication |
| healthy | output | 1 | Block is in the running state |
| status | output | 2 | 0 startup, 1 running, 2 retest, 3 failed |

## Verification
Two situations are the hardest to reach from the ports. The first is a failure that lands while a finished word is still waiting for the consumer. The second is a retest request that arrives during that wait. To reach both, the stimulus holds `rnd_ready` low after a word completes. It then drives a controlled run of equal samples, or pulses the retest input, and watches whether the offered word disappears or the retest waits. The startup window boundaries are reached by spreading exactly 461, 462, 562 and 563 ones evenly over 1024 samples, so that the stuck detector cannot trip first.

// File: rtl/trng_gate_pkg.sv
package trng_gate_pkg;
    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_RUN    = 2'd1,
        ST_RETEST = 2'd2,
        ST_FAIL   = 2'd3
    } gate_state_e;
endpackage

// File: rtl/trng_stuck_mon.sv
// Flags a run of LIMIT identical raw samples.
module trng_stuck_mon #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic smp_bit,
    output logic stuck_hit
);
    localparam int RW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          have;
        logic          last;
        logic [RW-1:0] run;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d     = mon_q;
        stuck_hit = 1'b0;
        if (smp_en) begin
            if (mon_q.have && (smp_bit == mon_q.last)) begin
                if (mon_q.run == RW'(LIMIT - 1)) begin
                    stuck_hit = 1'b1;
                end else begin
                    mon_d.run = mon_q.run + 1'b1;
                end
            end else begin
                mon_d.run = RW'(1);
            end
            mon_d.have = 1'b1;
            mon_d.last = smp_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end
endmodule

// File: rtl/trng_window_mon.sv
// Counts ones over a window of WIN samples while act is high.
module trng_window_mon #(
    parameter int WIN     = 1024,
    parameter int ONES_LO = 462,
    parameter int ONES_HI = 562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic smp_en,
    input  logic smp_bit,
    output logic win_done,
    output logic win_pass
);
    localparam int CW = $clog2(WIN);
    localparam int OW = $clog2(WIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [OW-1:0] ones;
    } win_t;

    win_t win_d, win_q;
    logic [OW-1:0] ones_nx;

    always_comb begin
        win_d    = win_q;
        win_done = 1'b0;
        win_pass = 1'b0;
        ones_nx  = win_q.ones + OW'(smp_bit);
        if (!act) begin
            win_d = '0;
        end else if (smp_en) begin
            if (win_q.cnt == CW'(WIN - 1)) begin
                win_done = 1'b1;
                win_pass = (ones_nx >= OW'(ONES_LO)) && (ones_nx <= OW'(ONES_HI));
                win_d    = '0;
            end else begin
                win_d.cnt  = win_q.cnt + 1'b1;
                win_d.ones = ones_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/trng_pair_packer.sv
// XORs sample pairs into conditioned bits and shifts them into a word.
module trng_pair_packer #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              smp_bit,
    input  logic              flush,
    output logic              word_done,
    output logic [WORD_W-1:0] word_out
);
    localparam int KW = $clog2(WORD_W);

    typedef struct packed {
        logic              have;
        logic              first;
        logic [WORD_W-1:0] acc;
        logic [KW-1:0]     cnt;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d      = pk_q;
        word_done = 1'b0;
        word_out  = {pk_q.acc[WORD_W-2:0], pk_q.first ^ smp_bit};
        if (flush) begin
            pk_d = '0;
        end else if (smp_en) begin
            if (!pk_q.have) begin
                pk_d.have  = 1'b1;
                pk_d.first = smp_bit;
            end else begin
                pk_d.have = 1'b0;
                pk_d.acc  = word_out;
                if (pk_q.cnt == KW'(WORD_W - 1)) begin
                    word_done = 1'b1;
                    pk_d.cnt  = '0;
                end else begin
                    pk_d.cnt = pk_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end
endmodule

// File: rtl/trng_gate_ctrl.sv
module trng_gate_ctrl
    import trng_gate_pkg::*;
#(
    parameter int WORD_W      = 128,
    parameter int STUCK_LIMIT = 64,
    parameter int WIN         = 1024,
    parameter int ONES_LO     = 462,
    parameter int ONES_HI     = 562
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_bit,
    input  logic              ent_vld,
    input  logic              retest_req,
    output logic [WORD_W-1:0] rnd_word,
    output logic              rnd_valid,
    input  logic              rnd_ready,
    output logic              fault,
    output logic              healthy,
    output logic [1:0]        status
);
    typedef struct packed {
        gate_state_e       state;
        logic              pend;
        logic              full;
        logic [WORD_W-1:0] word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              smp_live;
    logic              stuck_hit;
    logic              win_act;
    logic              win_done;
    logic              win_pass;
    logic              fail_now;
    logic              pk_en;
    logic              pk_flush;
    logic              pk_done;
    logic [WORD_W-1:0] pk_word;
    logic              pop;

    assign smp_live = ent_vld && (ctl_q.state != ST_FAIL);
    assign win_act  = (ctl_q.state == ST_START) || (ctl_q.state == ST_RETEST);
    assign fail_now = stuck_hit || (win_done && !win_pass);
    assign pk_en    = ent_vld && (ctl_q.state == ST_RUN) && !ctl_q.full;
    assign pk_flush = fail_now || (ctl_q.state == ST_FAIL);
    assign pop      = ctl_q.full && rnd_ready && (ctl_q.state == ST_RUN);

    trng_stuck_mon #(
        .LIMIT (STUCK_LIMIT)
    ) i_stuck (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_live),
        .smp_bit   (ent_bit),
        .stuck_hit (stuck_hit)
    );

    trng_window_mon #(
        .WIN     (WIN),
        .ONES_LO (ONES_LO),
        .ONES_HI (ONES_HI)
    ) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (win_act),
        .smp_en   (smp_live),
        .smp_bit  (ent_bit),
        .win_done (win_done),
        .win_pass (win_pass)
    );

    trng_pair_packer #(
        .WORD_W (WORD_W)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (pk_en),
        .smp_bit   (ent_bit),
        .flush     (pk_flush),
        .word_done (pk_done),
        .word_out  (pk_word)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_START: begin
                if (fail_now) begin
                    ctl_d.state = ST_FAIL;
                end else if (win_done) begin
                    ctl_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fail_now) begin
                    ctl_d.state = ST_FAIL;
                end else begin
                    if (pop) begin
                        ctl_d.full = 1'b0;
                    end
                    if (pk_done) begin
                        ctl_d.full = 1'b1;
                        ctl_d.word = pk_word;
                    end
                    if (retest_req || ctl_q.pend) begin
                        if (!ctl_q.full && !pk_done) begin
                            ctl_d.state = ST_RETEST;
                            ctl_d.pend  = 1'b0;
                        end else begin
                            ctl_d.pend = 1'b1;
                        end
                    end
                end
            end
            ST_RETEST: begin
                if (fail_now) begin
                    ctl_d.state = ST_FAIL;
                end else if (win_done) begin
                    ctl_d.state = ST_RUN;
                end
            end
            default: begin
                ctl_d.state = ST_FAIL;
            end
        endcase
        if (ctl_d.state == ST_FAIL) begin
            ctl_d.full = 1'b0;
            ctl_d.pend = 1'b0;
            ctl_d.word = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_START, pend: 1'b0, full: 1'b0, word: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rnd_word  = ctl_q.word;
    assign rnd_valid = ctl_q.full && (ctl_q.state == ST_RUN);
    assign fault     = (ctl_q.state == ST_FAIL);
    assign healthy   = (ctl_q.state == ST_RUN);
    assign status    = ctl_q.state;
endmodule

// File: rtl/trng_gate_chk.sv
module trng_gate_chk #(
    parameter int WORD_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rnd_ready,
    input logic              rnd_valid,
    input logic [WORD_W-1:0] rnd_word,
    input logic              fault,
    input logic [1:0]        status
);
    a_r3_valid_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> status == 2'd1);

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && !rnd_ready) |=> ((rnd_valid && $stable(rnd_word)) || fault));

    a_r10_no_retest_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |=> status != 2'd2);

    a_r2_startup_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0) |=> status != 2'd2);

    a_r9_retest_from_running: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2) |-> ($past(status) == 2'd1 || $past(status) == 2'd2));
endmodule

bind trng_gate_ctrl trng_gate_chk #(.WORD_W(WORD_W)) i_trng_gate_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rnd_ready (rnd_ready),
    .rnd_valid (rnd_valid),
    .rnd_word  (rnd_word),
    .fault     (fault),
    .status    (status)
);

// File: tb/test_trng_gate_ctrl.sv
`timescale 1ns/1ps
module test_trng_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 5;
    // stimulus: ones in startup window; expected status after the window
    localparam int TAB [NTAB][2] = '{'{461, 3}, '{462, 1}, '{512, 1}, '{562, 1}, '{563, 3}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ent_bit = 1'b0;
    logic         ent_vld = 1'b0;
    logic         retest_req = 1'b0;
    logic         rnd_ready = 1'b0;
    logic [127:0] rnd_word;
    logic         rnd_valid;
    logic         fault;
    logic         healthy;
    logic [1:0]   status;

    int   checks = 0;
    int   errors = 0;
    bit   ended = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    trng_gate_ctrl i_trng_gate_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent_bit    (ent_bit),
        .ent_vld    (ent_vld),
        .retest_req (retest_req),
        .rnd_word   (rnd_word),
        .rnd_valid  (rnd_valid),
        .rnd_ready  (rnd_ready),
        .fault      (fault),
        .healthy    (healthy),
        .status     (status)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic spread_bit(input int i, input int n);
        return ((i + 1) * n / 1024) != (i * n / 1024);
    endfunction

    function automatic logic lf_next();
        logic b;
        b  = lf[0];
        lf = (lf >> 1) ^ (b ? 16'hB400 : 16'h0000);
        return b;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ent_vld = 1'b0; retest_req = 1'b0; rnd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic feed(input logic b);
        @(negedge clk);
        ent_bit = b; ent_vld = 1'b1;
        @(posedge clk);
        #1 ent_vld = 1'b0;
    endtask

    task automatic feed_window(input int n, input int cnt);
        for (int i = 0; i < cnt; i++) feed(spread_bit(i, n));
    endtask

    task automatic feed_word(output logic [127:0] e);
        logic p;
        logic b;
        p = 1'b0;
        e = '0;
        for (int k = 0; k < 256; k++) begin
            b = lf_next();
            if (k % 2 == 0) p = b;
            else e[127 - k/2] = p ^ b;
            feed(b);
        end
    endtask

    task automatic pop();
        @(negedge clk);
        rnd_ready = 1'b1;
        @(posedge clk);
        #1 rnd_ready = 1'b0;
    endtask

    task automatic pulse_retest();
        @(negedge clk);
        retest_req = 1'b1;
        @(posedge clk);
        #1 retest_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [127:0] e1;
        logic [127:0] e2;
        logic [127:0] e3;

        // R1 reset state
        do_reset();
        #1;
        chk(status == 2'd0, "R1 status", status, 0);
        chk(!rnd_valid && !fault && !healthy, "R1 outputs", {rnd_valid, fault, healthy}, 0);

        // R2/R3 startup window boundaries from the table
        for (int t = 0; t < NTAB; t++) begin
            do_reset();
            feed_window(TAB[t][0], 1023);
            chk(status == 2'd0 && !rnd_valid, "R3 no output in startup", {status, rnd_valid}, 0);
            feed(spread_bit(1023, TAB[t][0]));
            chk(status == 2'(TAB[t][1]), "R2 window verdict", status, TAB[t][1]);
        end

        // R5/R6 conditioning and handshake
        do_reset();
        feed_window(512, 1024);
        chk(status == 2'd1 && healthy, "R2 running", status, 1);
        feed_word(e1);
        chk(rnd_valid, "R5 word valid", rnd_valid, 1);
        chk(rnd_word == e1, "R5 word value", rnd_word, e1);
        for (int i = 0; i < 100; i++) feed(lf_next());
        chk(rnd_valid && rnd_word == e1, "R6 word held", rnd_word, e1);
        pop();
        chk(!rnd_valid, "R6 taken", rnd_valid, 0);
        feed_word(e2);
        chk(rnd_valid && rnd_word == e2, "R6 held samples dropped", rnd_word, e2);
        pop();

        // R10 deferred retest, then R9 pass
        feed_word(e3);
        pulse_retest();
        chk(status == 2'd1 && rnd_valid && rnd_word == e3, "R10 retest waits", status, 1);
        pop();
        @(posedge clk);
        #1;
        chk(status == 2'd2, "R10 retest starts", status, 2);
        chk(!rnd_valid, "R9 no output in retest", rnd_valid, 0);
        feed_window(512, 1024);
        chk(status == 2'd1, "R9 retest pass", status, 1);

        // R4 stuck boundary in running, R7 partial discarded, R8 sticky
        for (int i = 0; i < 100; i++) feed(lf_next());
        feed(1'b0);
        for (int i = 0; i < 63; i++) feed(1'b1);
        chk(status == 2'd1, "R4 63 equal tolerated", status, 1);
        feed(1'b1);
        chk(status == 2'd3 && fault && !healthy, "R4 64 equal fails", status, 3);
        for (int i = 0; i < 256; i++) feed(lf_next());
        chk(!rnd_valid, "R7 no word after failure", rnd_valid, 0);
        pulse_retest();
        chk(status == 2'd3 && fault, "R8 sticky failure", status, 3);

        // R9 immediate retest that fails
        do_reset();
        feed_window(512, 1024);
        pulse_retest();
        chk(status == 2'd2, "R9 retest entry", status, 2);
        feed_window(600, 1024);
        chk(status == 2'd3, "R9 retest fail", status, 3);

        // R7 held word discarded on failure
        do_reset();
        feed_window(512, 1024);
        feed_word(e1);
        chk(rnd_valid, "R7 word held before fault", rnd_valid, 1);
        feed(1'b0);
        for (int i = 0; i < 64; i++) feed(1'b1);
        chk(!rnd_valid && fault, "R7 held word dropped", {rnd_valid, fault}, 1);

        // R4 stuck during startup
        do_reset();
        for (int i = 0; i < 63; i++) feed(1'b0);
        chk(status == 2'd0, "R4 startup 63 zeros", status, 0);
        feed(1'b0);
        chk(status == 2'd3, "R4 startup 64 zeros", status, 3);

        finish_run();
    end
endmodule